// File: doc/BRIEF.md
# Line-Rate Phase-Frequency Detector for Oscillator Steering

This block keeps a transmit clock in step with the rate of received video. A loopback path carries decoded receive data into a buffer that the transmit side drains. If the transmit clock runs even a few ppm away from the receive rate, that buffer slowly fills up or empties. The block compares the line sync pulse recovered from the incoming video with a feedback pulse. The feedback pulse comes from dividing the transmit clock by the number of clocks in one video line. The block then drives separate raise and lower lines to an external voltage-controlled crystal oscillator of about 148.5 or 148.35 MHz, through an analog loop filter that lies outside the block.

The sync pulse arrives from another clock domain, so a synchronizer chain brings it in and its rising edge is detected. Steering only happens while both the frame lock and the timing-reference lock are high. When lock is gained, the divider waits for the first sync edge and starts its count from that edge. This first edge produces no correction. From then on, the raise line is set by a reference edge and the lower line is set by a feedback edge. When both are set, both clear on the next clock, which is the usual three-state detector behaviour.

Top module: `hsync_pfd_steer`

## Requirements
- R1: While rst_n is low, up_o and dn_o are 0 and the divider is disarmed.
- R2: A rising edge of sync_in, after SYNC_STAGES synchronizer flops, counts as one reference event no matter how many clocks the pulse stays high. The event shows as a detector input one clock after the edge leaves the synchronizer.
- R3: Once armed, the divider emits one feedback event every line_len clocks. line_len must be at least 2.
- R4: A reference event (while armed) sets up_o and a feedback event sets dn_o. Each stays set until both are set. When up_o and dn_o are both 1, both are 0 on the next clock.
- R5: While frame_lock_i and trs_lock_i are not both 1, up_o and dn_o are 0 from the next clock on, and the divider is disarmed.
- R6: The first reference event after lock arms the divider with count 0. That event does not set up_o, and the first feedback event follows line_len clocks later.
- R7: When the sync period equals line_len after arming, every line gives exactly one clock with up_o and dn_o both 1, and no other up_o or dn_o activity.
- R8: If line_len is lowered while the count is at or above the new limit, the divider emits a feedback event and wraps to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Line sync pulse recovered from received video (asynchronous) |
| line_len | input | DIV_W | Transmit clocks per video line for the current standard |
| frame_lock_i | input | 1 | Receiver frame lock |
| trs_lock_i | input | 1 | Receiver timing-reference lock |
| up_o | output | 1 | Raise oscillator frequency |
| dn_o | output | 1 | Lower oscillator frequency |

## Verification
The assertions check the detector's rules on every clock:
- raise and lower, once both set, clear together on the next clock;
- each line, once set, holds while lock is present;
- both lines go quiet one clock after lock is lost;
- the raise line never rises unless the divider was armed beforehand.

Other behaviour depends on timing and can only be shown by the bench scenarios, which compare against a reference model on every clock:
- the re-phasing on the first edge after lock;
- the direction of steering for a fast or slow sync period;
- the single coincident pulse per line when the rates match;
- counting a long sync pulse only once;
- the wrap when line_len shrinks.

// File: rtl/hsync_pfd_steer_pkg.sv
package hsync_pfd_steer_pkg;
   // Detector state: bit 1 = raise, bit 0 = lower
   typedef enum logic [1:0] {
      PFD_IDLE = 2'b00,
      PFD_DN   = 2'b01,
      PFD_UP   = 2'b10,
      PFD_BOTH = 2'b11
   } pfd_state_e;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ref_edge_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];

   assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/line_divider.sv
module line_divider #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             locked,
   input  logic             rephase,
   input  logic [DIV_W-1:0] line_len,
   output logic             armed,
   output logic             fb_tick
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;

   assign fb_tick = armed && (cnt >= line_len - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (!locked) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (!armed) begin
         if (rephase) begin
            armed <= 1'b1;
            cnt   <= '0;
         end
      end else begin
         cnt <= fb_tick ? '0 : cnt + ONE;
      end
   end
endmodule

// File: rtl/tri_state_pfd.sv
module tri_state_pfd
   import hsync_pfd_steer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic locked,
   input  logic ref_hit,
   input  logic fb_hit,
   output logic up,
   output logic dn
);
   pfd_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                st <= PFD_IDLE;
      else if (!locked)          st <= PFD_IDLE;
      else if (st == PFD_BOTH)   st <= PFD_IDLE;
      else st <= pfd_state_e'({st[1] | ref_hit, st[0] | fb_hit});
   end

   assign up = st[1];
   assign dn = st[0];
endmodule

// File: rtl/hsync_pfd_steer.sv
module hsync_pfd_steer #(
   parameter int DIV_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_in,
   input  logic [DIV_W-1:0] line_len,
   input  logic             frame_lock_i,
   input  logic             trs_lock_i,
   output logic             up_o,
   output logic             dn_o
);
   generate
      if (DIV_W < 2) begin : g_bad_w
         $error("hsync_pfd_steer: DIV_W must be at least 2");
      end
   endgenerate

   logic locked, ref_rise, armed, fb_tick, ref_hit;

   assign locked  = frame_lock_i & trs_lock_i;
   assign ref_hit = ref_rise & armed;

   ref_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .din(sync_in), .rise(ref_rise)
   );

   line_divider #(.DIV_W(DIV_W)) i_div (
      .clk(clk), .rst_n(rst_n), .locked(locked), .rephase(ref_rise),
      .line_len(line_len), .armed(armed), .fb_tick(fb_tick)
   );

   tri_state_pfd i_pfd (
      .clk(clk), .rst_n(rst_n), .locked(locked),
      .ref_hit(ref_hit), .fb_hit(fb_tick), .up(up_o), .dn(dn_o)
   );
endmodule

// File: rtl/hsync_pfd_steer_chk.sv
module hsync_pfd_steer_chk (
   input logic clk,
   input logic rst_n,
   input logic frame_lock_i,
   input logic trs_lock_i,
   input logic armed,
   input logic up_o,
   input logic dn_o
);
   AST_BOTH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (up_o && dn_o) |=> (!up_o && !dn_o)); // R4
   AST_UNLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_lock_i && trs_lock_i) |=> (!up_o && !dn_o)); // R5
   AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (up_o && !dn_o && frame_lock_i && trs_lock_i) |=> up_o); // R4
   AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_o && !up_o && frame_lock_i && trs_lock_i) |=> dn_o); // R4
   AST_UP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(up_o) |-> $past(armed)); // R6
endmodule

bind hsync_pfd_steer hsync_pfd_steer_chk i_chk (
   .clk(clk), .rst_n(rst_n), .frame_lock_i(frame_lock_i),
   .trs_lock_i(trs_lock_i), .armed(armed), .up_o(up_o), .dn_o(dn_o)
);

// File: tb/test_hsync_pfd_steer.sv
`timescale 1ns/1ps
module test_hsync_pfd_steer;
   localparam int DIV_W = 12;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_in = 1'b0;
   logic [DIV_W-1:0] line_len = 12'd20;
   logic frame_lock_i = 1'b0;
   logic trs_lock_i = 1'b0;
   logic up_o, dn_o;

   always #4 clk = ~clk;

   hsync_pfd_steer #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC)) i_hsync_pfd_steer (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .line_len(line_len),
      .frame_lock_i(frame_lock_i), .trs_lock_i(trs_lock_i),
      .up_o(up_o), .dn_o(dn_o)
   );

   int n_checks = 0, n_fail = 0;
   string cur_req = "R1";
   int n_up, n_dn, n_both, n_uprise;
   bit prev_up = 0;

   // behavioural reference model
   bit m_q[$];
   bit m_prev, m_armed, m_up, m_dn;
   int m_cnt;
   bit rr, fbt, lk, was;

   initial for (int i = 0; i < SYNC; i++) m_q.push_back(1'b0);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         for (int i = 0; i < SYNC; i++) m_q.push_back(1'b0);
         m_prev = 0; m_armed = 0; m_cnt = 0; m_up = 0; m_dn = 0;
      end else begin
         rr  = m_q[0] && !m_prev;
         fbt = m_armed && (m_cnt >= int'(line_len) - 1);
         lk  = frame_lock_i && trs_lock_i;
         was = m_armed;
         m_prev = m_q[0];
         void'(m_q.pop_front());
         m_q.push_back(sync_in);
         if (!lk) begin
            m_armed = 0; m_cnt = 0; m_up = 0; m_dn = 0;
         end else begin
            if (!m_armed) begin
               if (rr) begin m_armed = 1; m_cnt = 0; end
            end else m_cnt = fbt ? 0 : m_cnt + 1;
            if (m_up && m_dn) begin m_up = 0; m_dn = 0; end
            else begin
               m_up = m_up | (rr && was);
               m_dn = m_dn | fbt;
            end
         end
      end
   end

   task automatic check(string req, bit ok, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check(cur_req, {up_o, dn_o} == {m_up, m_dn}, {up_o, dn_o}, {m_up, m_dn});
      if (up_o) n_up++;
      if (dn_o) n_dn++;
      if (up_o && dn_o) n_both++;
      if (up_o && !prev_up) n_uprise++;
      prev_up = up_o;
   endtask

   task automatic clr();
      n_up = 0; n_dn = 0; n_both = 0; n_uprise = 0;
   endtask

   task automatic run_lines(int period, int lines, int width);
      for (int l = 0; l < lines; l++)
         for (int c = 0; c < period; c++) begin
            sync_in = (c < width);
            tick();
         end
      sync_in = 0;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      clr();
      repeat (4) tick();
      check("R1", !up_o && !dn_o, {up_o, dn_o}, 0);
      rst_n = 1;
      // unlocked: pulses must not steer
      cur_req = "R5"; clr();
      run_lines(20, 2, 3);
      check("R5", n_up + n_dn == 0, n_up + n_dn, 0);
      // lock: first edge only re-phases
      frame_lock_i = 1; trs_lock_i = 1;
      cur_req = "R6"; clr();
      run_lines(20, 1, 3);
      check("R6", n_up + n_dn == 0, n_up + n_dn, 0);
      // matched rate
      cur_req = "R7"; clr();
      run_lines(20, 6, 3);
      check("R7", n_both == 6, n_both, 6);
      check("R7", n_up == 6 && n_dn == 6, n_up + n_dn, 12);
      // sync faster than divider
      cur_req = "R4"; clr();
      run_lines(17, 8, 2);
      check("R4", n_up > n_dn, n_up, n_dn + 1);
      // sync slower than divider
      cur_req = "R3"; clr();
      run_lines(23, 8, 2);
      check("R3", n_dn > n_up, n_dn, n_up + 1);
      // lock loss
      cur_req = "R5";
      trs_lock_i = 0;
      tick(); tick();
      check("R5", !up_o && !dn_o, {up_o, dn_o}, 0);
      clr();
      run_lines(20, 1, 3);
      check("R5", n_up + n_dn == 0, n_up + n_dn, 0);
      trs_lock_i = 1;
      cur_req = "R6"; clr();
      run_lines(20, 1, 3);
      check("R6", n_up == 0, n_up, 0);
      // shrink line length mid-line
      cur_req = "R8";
      run_lines(20, 1, 3);
      sync_in = 0;
      repeat (15) tick();
      line_len = 12'd12; clr();
      run_lines(12, 6, 3);
      check("R8", n_dn >= 6, n_dn, 6);
      // long sync pulse counted once
      cur_req = "R2";
      run_lines(12, 1, 8);
      clr();
      run_lines(12, 5, 8);
      check("R2", n_uprise == 5, n_uprise, 5);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule